// File: doc/BRIEF.md
# Power-On Strap Latch Sequencer

This block runs the power-up sequence for two shared pins. Each pin is first read as a frequency-select strap and then driven as a clock output. The block starts counting when the power-good signal comes up. For a fixed number of reference-clock cycles it holds both pin drivers in high impedance and keeps every clock output of the chip LOW. At the end of that window it captures the level on each pin as a select bit. In the same cycle it turns on the pin drivers and the clock outputs.

The two captured select bits are decoded into a processor-clock rate code and a memory-clock rate code. The captured bits keep their value until power-good drops again. No other event changes them, so the pins can be used as ordinary clock outputs for the rest of the power-on period. Each pin level reaches the capture register through a two-flop synchronizer.

The window length is a parameter counted in reference ticks. Its default is 28636 ticks, which is 2 ms at a 14.318 MHz reference.

Top module: `strap_seq_top`

## Requirements
- R1: After `pwr_ok_n` goes high, `done`, both bits of `pin_oe` and `clk_run` stay 0 for the first WINDOW_TICKS-1 rising clock edges. All of them go to 1 together on rising edge number WINDOW_TICKS.
- R2: `fs` holds the level that `pin_in` had at rising edge WINDOW_TICKS-2, two synchronizer stages before capture. `fs[0]` comes from `pin_in[0]` and `fs[1]` comes from `pin_in[1]`. A change of `pin_in` made after that edge is not captured.
- R3: Once `done` is 1, it stays 1, and `pin_oe` stays 2'b11 and `clk_run` stays 1, until `pwr_ok_n` goes low.
- R4: After `done` is 1, changes on `pin_in` have no effect on `fs`, `cpu_code` or `mem_code`.
- R5: `cpu_code` encodes 0 = 66 MHz, 1 = 100 MHz and 2 = 133 MHz, and never takes the value 3. `mem_code` encodes 0 = 100 MHz and 1 = 133 MHz. The decode of fs[1:0] is:
  - 00 gives cpu 0 / mem 0
  - 01 gives cpu 1 / mem 0
  - 10 gives cpu 2 / mem 1
  - 11 gives cpu 2 / mem 0
- R6: While `done` is 0, `clk_run` is 0, so every clock output is held LOW and no partial cycle leaves the chip.
- R7: `pwr_ok_n` low clears `done`, `pin_oe`, `clk_run` and `fs` at once, without waiting for a clock edge. Its release starts a fresh full window and a fresh capture. This holds even when power-good drops in the middle of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock; one cycle is one window tick |
| pwr_ok_n | input | 1 | Power-good, active high; low is a power loss and clears all state |
| pin_in | input | 2 | Levels read back from the two shared strap/clock pins |
| pin_oe | output | 2 | Output-buffer enables for the two shared pins |
| clk_run | output | 1 | Enable for all clock outputs; 0 holds them LOW |
| done | output | 1 | Capture finished; high in the same cycle the enables turn on |
| fs | output | 2 | Captured select bits, fs[1] from pin 1, fs[0] from pin 0 |
| cpu_code | output | 2 | Decoded processor-clock rate code |
| mem_code | output | 1 | Decoded memory-clock rate code |

## Verification
A wrong window counter appears at the ports as `done` and the enables rising one or more edges early or late. The bench checks the exact edge of every window it runs.

A wrong synchronizer depth or a wrong capture moment shows up as a mismatched `fs` in the cycle right after `done` rises. Pin changes placed exactly at the capture boundary catch an off-by-one here.

A capture register that is not frozen shows up as `fs` following `pin_in` within one cycle of a later pin change. A decode error shows up in the rate codes for one of the four select values.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int STRAP_BITS = 2;

    typedef enum logic [1:0] {
        CPU_66  = 2'd0,
        CPU_100 = 2'd1,
        CPU_133 = 2'd2
    } cpu_rate_e;

    typedef enum logic {
        MEM_100 = 1'b0,
        MEM_133 = 1'b1
    } mem_rate_e;

    typedef struct packed {
        logic                  done;
        logic [STRAP_BITS-1:0] fs;
    } capture_st_t;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             pwr_ok_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge pwr_ok_n) begin
        if (!pwr_ok_n) st_q <= '0;
        else           st_q <= st_d;
    end

    assign sync_out = st_q.stable;

    // The second stage always carries what the first stage held one cycle earlier
    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        1'b1 |=> (st_q.stable == $past(st_q.meta))); // R2

endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int TICKS = 28636
) (
    input  logic clk,
    input  logic pwr_ok_n,
    output logic expire
);

    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fin;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    at_last;

    assign at_last = (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!st_q.fin) begin
            if (at_last) st_d.fin = 1'b1;
            else         st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pwr_ok_n) begin
        if (!pwr_ok_n) st_q <= '0;
        else           st_q <= st_d;
    end

    assign expire = !st_q.fin && at_last;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        st_q.cnt <= LAST); // R1

    AST_EXPIRE_ONCE: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        expire |=> (!expire && st_q.fin)); // R3

endmodule

// File: rtl/strap_fs_decode.sv
module strap_fs_decode
    import strap_pkg::*;
(
    input  logic [STRAP_BITS-1:0] fs,
    output logic [1:0]            cpu_code,
    output logic                  mem_code
);

    cpu_rate_e cpu_r;
    mem_rate_e mem_r;

    always_comb begin
        unique case (fs)
            2'b00:   begin cpu_r = CPU_66;  mem_r = MEM_100; end
            2'b01:   begin cpu_r = CPU_100; mem_r = MEM_100; end
            2'b10:   begin cpu_r = CPU_133; mem_r = MEM_133; end
            default: begin cpu_r = CPU_133; mem_r = MEM_100; end
        endcase
    end

    assign cpu_code = cpu_r;
    assign mem_code = mem_r;

    always_comb begin
        AST_CPU_CODE_LEGAL: assert (cpu_code != 2'd3); // R5
    end

endmodule

// File: rtl/strap_seq_top.sv
module strap_seq_top
    import strap_pkg::*;
#(
    parameter int WINDOW_TICKS = 28636
) (
    input  logic       clk,
    input  logic       pwr_ok_n,
    input  logic [1:0] pin_in,
    output logic [1:0] pin_oe,
    output logic       clk_run,
    output logic       done,
    output logic [1:0] fs,
    output logic [1:0] cpu_code,
    output logic       mem_code
);

    logic [STRAP_BITS-1:0] pin_sync;
    logic                  win_expire;
    capture_st_t           cap_d, cap_q;

    strap_sync #(.WIDTH(STRAP_BITS)) sync_i (
        .clk      (clk),
        .pwr_ok_n (pwr_ok_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    strap_window_timer #(.TICKS(WINDOW_TICKS)) timer_i (
        .clk      (clk),
        .pwr_ok_n (pwr_ok_n),
        .expire   (win_expire)
    );

    always_comb begin
        cap_d = cap_q;
        if (win_expire && !cap_q.done) begin
            cap_d.done = 1'b1;
            cap_d.fs   = pin_sync;
        end
    end

    always_ff @(posedge clk or negedge pwr_ok_n) begin
        if (!pwr_ok_n) cap_q <= '0;
        else           cap_q <= cap_d;
    end

    genvar g;
    generate
        for (g = 0; g < STRAP_BITS; g++) begin : g_oe
            assign pin_oe[g] = cap_q.done;
        end
    endgenerate

    assign clk_run = cap_q.done;
    assign done    = cap_q.done;
    assign fs      = cap_q.fs;

    strap_fs_decode dec_i (
        .fs       (cap_q.fs),
        .cpu_code (cpu_code),
        .mem_code (mem_code)
    );

    AST_LATCH_MATCH: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        $rose(done) |-> (fs == $past(pin_sync))); // R2

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        done |=> (done && pin_oe == 2'b11 && clk_run)); // R3

    AST_FS_FROZEN: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        (done && $past(done)) |-> $stable(fs)); // R4

    AST_DONE_ON_EXPIRE: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        $rose(done) |-> $past(win_expire)); // R1

    AST_QUIET_IN_WINDOW: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        !done |-> (pin_oe == 2'b00 && !clk_run && fs == 2'b00)); // R6

endmodule

// File: tb/strap_seq_top_tb_top.sv
module strap_seq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 40;

    logic       clk = 1'b0;
    logic       pwr_ok_n = 1'b0;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_oe;
    logic       clk_run;
    logic       done;
    logic [1:0] fs;
    logic [1:0] cpu_code;
    logic       mem_code;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_seq_top #(.WINDOW_TICKS(WIN)) dut_i (
        .clk      (clk),
        .pwr_ok_n (pwr_ok_n),
        .pin_in   (pin_in),
        .pin_oe   (pin_oe),
        .clk_run  (clk_run),
        .done     (done),
        .fs       (fs),
        .cpu_code (cpu_code),
        .mem_code (mem_code)
    );

    function automatic logic [1:0] exp_cpu(input logic [1:0] s);
        case (s)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic exp_mem(input logic [1:0] s);
        return (s == 2'b10);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Power down, check the cleared state, release, then walk the window.
    // late_pins replaces pins at the negedge after edge change_at (0 = no change).
    task automatic run_window(input logic [1:0] pins, input logic [1:0] late_pins,
                              input int change_at, input logic [1:0] expect_fs);
        int early;
        @(negedge clk);
        pwr_ok_n = 1'b0;
        pin_in   = pins;
        #1;
        chk("R7 clear done", done, 0);
        chk("R7 clear oe", pin_oe, 0);
        chk("R7 clear fs", fs, 0);
        @(negedge clk);
        pwr_ok_n = 1'b1;
        early = 0;
        for (int i = 1; i < WIN; i++) begin
            @(negedge clk);
            if (done || pin_oe != 2'b00 || clk_run) early++;
            if (fs != 2'b00) early++;
            if (i == change_at) pin_in = late_pins;
        end
        chk("R1/R6 quiet window", early, 0);
        @(negedge clk);
        chk("R1 done at edge", done, 1);
        chk("R1 oe at edge", pin_oe, 3);
        chk("R6 clk_run at edge", clk_run, 1);
        chk("R2 captured fs", fs, expect_fs);
        chk("R5 cpu_code", cpu_code, exp_cpu(expect_fs));
        chk("R5 mem_code", mem_code, exp_mem(expect_fs));
    endtask

    task automatic after_done_noise(input logic [1:0] held);
        for (int k = 0; k < 6; k++) begin
            pin_in = 2'($urandom);
            @(negedge clk);
            @(negedge clk);
            @(negedge clk);
            chk("R4 fs frozen", fs, held);
            chk("R4 cpu frozen", cpu_code, exp_cpu(held));
            chk("R4 mem frozen", mem_code, exp_mem(held));
            chk("R3 done sticky", {done, clk_run, pin_oe}, 4'hF);
        end
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired after %0d cycles expected completion", cycles);
        summary();
    end

    initial begin
        logic [1:0] r;
        void'($urandom(32'h5EED_0042));
        #1;
        chk("R7 reset done", done, 0);
        chk("R6 reset clk_run", clk_run, 0);

        // Directed: every select value, R5 decode table
        for (int v = 0; v < 4; v++) begin
            run_window(2'(v), 2'(v), 0, 2'(v));
            after_done_noise(2'(v));
        end

        // R2 boundary: change just after edge WIN-2 is too late
        run_window(2'b01, 2'b10, WIN-2, 2'b01);
        // R2 boundary: change just after edge WIN-3 is captured
        run_window(2'b01, 2'b10, WIN-3, 2'b10);

        // R7: power loss mid-window, then a complete fresh window
        @(negedge clk);
        pwr_ok_n = 1'b0;
        pin_in   = 2'b11;
        @(negedge clk);
        pwr_ok_n = 1'b1;
        repeat (WIN/2) @(negedge clk);
        pwr_ok_n = 1'b0;
        #1;
        chk("R7 mid-window drop done", done, 0);
        chk("R7 mid-window drop oe", pin_oe, 0);
        run_window(2'b10, 2'b10, 0, 2'b10);

        // R7: power loss after capture clears the latched bits
        @(negedge clk);
        pwr_ok_n = 1'b0;
        #1;
        chk("R7 post-capture clear fs", fs, 0);
        chk("R7 post-capture clear run", clk_run, 0);

        // Constrained random windows
        for (int t = 0; t < 10; t++) begin
            r = 2'($urandom);
            run_window(r, r, 0, r);
            after_done_noise(r);
        end

        summary();
    end

endmodule